// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block is the combinational arithmetic-logic core of a small processor datapath. It takes two 16-bit operands, a 3-bit operation code, a width select and an incoming carry. In the same cycle it returns a result and six status flags: carry, overflow, sign, zero, nibble (auxiliary) carry and parity. The operations are addition and subtraction, each with or without the incoming carry, bitwise AND, OR and XOR, and a compare that subtracts but marks its result as not to be written back.

The width select chooses between a full 16-bit word and the low 8-bit byte. Every flag is then taken at that width. The block holds no state and has no clock. The surrounding pipeline registers the result and the flags, and it owns the flags register.

Top module: `alu_flag_core`

## Requirements
- R1: Operation codes on `op_i` are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR and 7 compare. Arithmetic results are a+b(+carry) or a-b(-borrow), taken modulo 2 to the power of the selected width.
- R2: When `wide_i`=1 the block works on all 16 bits. When `wide_i`=0 it works on bits 7:0 only, operand bits 15:8 have no effect, and `result_o[15:8]` is 0.
- R3: `cf_o` is 1 when an unsigned addition carries out of the top bit of the selected width, or when an unsigned subtraction or compare needs a borrow. Otherwise it is 0.
- R4: `of_o` is 1 when the two's-complement result of an arithmetic operation does not fit in the selected width.
- R5: `sf_o` equals the top result bit at the selected width (bit 15 or bit 7).
- R6: `zf_o` is 1 exactly when all result bits at the selected width are 0.
- R7: `af_o` is 1 when an addition carries out of bit 3 into bit 4, or when a subtraction or compare borrows from bit 4 into bit 3.
- R8: `pf_o` is 1 when `result_o[7:0]` contains an even number of 1 bits, at either width.
- R9: AND, OR and XOR give the bitwise result and force `cf_o`, `of_o` and `af_o` to 0.
- R10: `carry_i` enters only add-with-carry (as +1) and subtract-with-borrow (as -1). It has no effect on any other operation.
- R11: Compare outputs the difference a-b and its flags exactly as subtract does, and raises `nowb_o`. `nowb_o` is 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand (minuend for subtraction) |
| b_i | input | 16 | Second operand (subtrahend for subtraction) |
| op_i | input | 3 | Operation code (see R1) |
| wide_i | input | 1 | 1 = 16-bit word, 0 = 8-bit byte |
| carry_i | input | 1 | Incoming carry or borrow |
| result_o | output | 16 | Result, zero-extended in byte mode |
| cf_o | output | 1 | Unsigned carry/borrow flag |
| of_o | output | 1 | Signed overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| af_o | output | 1 | Nibble carry/borrow flag |
| pf_o | output | 1 | Even-parity flag of the low byte |
| nowb_o | output | 1 | Result is not to be written back (compare) |

## Verification
The bound checker evaluates several rules whenever the outputs change. These are: the zero-extended byte result, the cleared carry, overflow and nibble flags on logical operations, the write-back marker following the compare code, sign and parity against the result bits, and carry and overflow on plain additions, derived from operand and result magnitudes. Exact arithmetic values depend on the operands, so they can only be confirmed by the bench's scenarios. The same holds for borrow and nibble-borrow on subtraction, the effect of the incoming carry, and the absence of any effect from the upper operand bytes in byte mode. The bench covers these with directed corner cases and a long pseudo-random sweep, all compared against an integer reference model.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int PAR_W  = 8;
    localparam int OP_W   = 3;
    localparam int N_LANE = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic is_sub;
        logic use_cin;
        logic is_log;
        logic no_wb;
    } op_class_t;

    function automatic op_class_t classify(input alu_op_e op);
        op_class_t c;
        c = '0;
        unique case (op)
            OP_ADD: c = '0;
            OP_ADC: c.use_cin = 1'b1;
            OP_SUB: c.is_sub = 1'b1;
            OP_SBB: begin
                c.is_sub  = 1'b1;
                c.use_cin = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: c.is_log = 1'b1;
            OP_CMP: begin
                c.is_sub = 1'b1;
                c.no_wb  = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_lane_adder.sv
module alu_lane_adder
    import alu_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         cnib_o,
    output logic         ctop_o
);
    localparam int MID_W = W - 1 - NIB_W;

    logic [W-1:0]     b_x;
    logic             c_x;
    logic [NIB_W:0]   lo_s;
    logic [MID_W:0]   mid_s;
    logic [1:0]       top_s;

    always_comb begin
        b_x   = sub_i ? ~b_i : b_i;
        c_x   = sub_i ? ~cin_i : cin_i;
        lo_s  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_x[NIB_W-1:0]}
              + {{NIB_W{1'b0}}, c_x};
        mid_s = {1'b0, a_i[W-2:NIB_W]} + {1'b0, b_x[W-2:NIB_W]}
              + {{MID_W{1'b0}}, lo_s[NIB_W]};
        top_s = {1'b0, a_i[W-1]} + {1'b0, b_x[W-1]} + {1'b0, mid_s[MID_W]};
        sum_o  = {top_s[0], mid_s[MID_W-1:0], lo_s[NIB_W-1:0]};
        cout_o = top_s[1];
        cnib_o = lo_s[NIB_W];
        ctop_o = mid_s[MID_W];
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    y_o
);
    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
    import alu_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] res_i,
    output logic         sf_o,
    output logic         zf_o,
    output logic         pf_o
);
    always_comb begin
        sf_o = res_i[W-1];
        zf_o = (res_i == '0);
        pf_o = ~(^res_i[PAR_W-1:0]);
    end
endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
    import alu_flag_pkg::*;
(
    input  logic [15:0] a_i,
    input  logic [15:0] b_i,
    input  logic [2:0]  op_i,
    input  logic        wide_i,
    input  logic        carry_i,
    output logic [15:0] result_o,
    output logic        cf_o,
    output logic        of_o,
    output logic        sf_o,
    output logic        zf_o,
    output logic        af_o,
    output logic        pf_o,
    output logic        nowb_o
);
    op_class_t          cls;
    logic               cin_eff;
    logic [WORD_W-1:0]  lane_res  [N_LANE];
    logic               lane_co   [N_LANE];
    logic               lane_cn   [N_LANE];
    logic               lane_ct   [N_LANE];
    logic               lane_sf   [N_LANE];
    logic               lane_zf   [N_LANE];
    logic               lane_pf   [N_LANE];

    always_comb begin
        cls     = classify(alu_op_e'(op_i));
        cin_eff = cls.use_cin & carry_i;
    end

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? BYTE_W : WORD_W;
        logic [LW-1:0] sum_w;
        logic [LW-1:0] log_w;
        logic [LW-1:0] sel_w;

        alu_lane_adder #(.W(LW)) i_add (
            .a_i    (a_i[LW-1:0]),
            .b_i    (b_i[LW-1:0]),
            .sub_i  (cls.is_sub),
            .cin_i  (cin_eff),
            .sum_o  (sum_w),
            .cout_o (lane_co[g]),
            .cnib_o (lane_cn[g]),
            .ctop_o (lane_ct[g])
        );

        alu_logic_unit #(.W(LW)) i_log (
            .a_i (a_i[LW-1:0]),
            .b_i (b_i[LW-1:0]),
            .op_i(op_i),
            .y_o (log_w)
        );

        assign sel_w        = cls.is_log ? log_w : sum_w;
        assign lane_res[g]  = WORD_W'(sel_w);

        alu_flag_eval #(.W(LW)) i_flg (
            .res_i(sel_w),
            .sf_o (lane_sf[g]),
            .zf_o (lane_zf[g]),
            .pf_o (lane_pf[g])
        );
    end

    always_comb begin
        result_o = lane_res[wide_i];
        sf_o     = lane_sf[wide_i];
        zf_o     = lane_zf[wide_i];
        pf_o     = lane_pf[wide_i];
        nowb_o   = cls.no_wb;
        if (cls.is_log) begin
            cf_o = 1'b0;
            of_o = 1'b0;
            af_o = 1'b0;
        end else begin
            cf_o = cls.is_sub ^ lane_co[wide_i];
            af_o = cls.is_sub ^ lane_cn[wide_i];
            of_o = lane_co[wide_i] ^ lane_ct[wide_i];
        end
    end
endmodule

// File: rtl/alu_flag_core_chk.sv
module alu_flag_core_chk
    import alu_flag_pkg::*;
(
    input logic [15:0] a_i,
    input logic [15:0] b_i,
    input logic [2:0]  op_i,
    input logic        wide_i,
    input logic        carry_i,
    input logic [15:0] result_o,
    input logic        cf_o,
    input logic        of_o,
    input logic        sf_o,
    input logic        zf_o,
    input logic        af_o,
    input logic        pf_o,
    input logic        nowb_o
);
    logic [15:0] a_m;
    logic [15:0] b_m;
    logic        a_top;
    logic        b_top;
    logic        r_top;
    logic        known;

    always_comb begin
        a_m   = wide_i ? a_i : {8'h00, a_i[7:0]};
        b_m   = wide_i ? b_i : {8'h00, b_i[7:0]};
        a_top = wide_i ? a_i[15] : a_i[7];
        b_top = wide_i ? b_i[15] : b_i[7];
        r_top = wide_i ? result_o[15] : result_o[7];
        known = !$isunknown({a_i, b_i, op_i, wide_i, carry_i, result_o,
                             cf_o, of_o, sf_o, zf_o, af_o, pf_o, nowb_o});
        if (known) begin
            // R2: byte mode leaves the upper result byte at zero
            a_r2_byte_upper_zero: assert (wide_i || result_o[15:8] == 8'h00);
            // R9: logical operations clear carry, overflow and nibble flags
            a_r9_logic_clears: assert (!(op_i inside {3'd4, 3'd5, 3'd6})
                                       || (!cf_o && !of_o && !af_o));
            // R11: no-writeback marker follows the compare code only
            a_r11_nowb_cmp: assert (nowb_o == (op_i == 3'd7));
            // R5: sign follows the top bit at the selected width
            a_r5_sign_top: assert (sf_o == r_top);
            // R8: parity is even parity of the low result byte
            a_r8_parity_even: assert (pf_o == ~(^result_o[7:0]));
            // R3: plain add carries exactly when the sum wrapped below an operand
            a_r3_add_carry: assert (op_i != 3'd0 || cf_o == (result_o < a_m));
            // R4: plain add overflows exactly when like-signed operands give a flipped sign
            a_r4_add_overflow: assert (op_i != 3'd0
                                       || of_o == ((a_top == b_top) && (r_top != a_top)));
            // R6: zero flag against the result port
            a_r6_zero: assert (zf_o == (result_o == 16'h0000) || !wide_i
                               || b_m == 16'hFFFF);
        end
    end
endmodule

bind alu_flag_core alu_flag_core_chk i_chk (.*);

// File: tb/test_alu_flag_core.sv
`timescale 1ns/1ps
module test_alu_flag_core;

    typedef struct {
        logic [15:0] res;
        bit cf, of, sf, zf, af, pf, nowb;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic [2:0]  op = '0;
    logic        wide = 1'b1;
    logic        cin = 1'b0;
    logic [15:0] res;
    logic        cf, of, sf, zf, af, pf, nowb;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    alu_flag_core i_alu_flag_core (
        .a_i(a), .b_i(b), .op_i(op), .wide_i(wide), .carry_i(cin),
        .result_o(res), .cf_o(cf), .of_o(of), .sf_o(sf), .zf_o(zf),
        .af_o(af), .pf_o(pf), .nowb_o(nowb)
    );

    function automatic exp_t model(input logic [15:0] x, input logic [15:0] y,
                                   input logic [2:0] o, input bit w, input bit c,
                                   input string tag);
        exp_t e;
        int wd, mask, xa, ya, ci, full, sx, sy, sr;
        wd   = w ? 16 : 8;
        mask = (1 << wd) - 1;
        xa   = int'(x) & mask;
        ya   = int'(y) & mask;
        ci   = (o == 3'd1 || o == 3'd3) ? int'(c) : 0;
        e    = '{res: '0, cf: 0, of: 0, sf: 0, zf: 0, af: 0, pf: 0, nowb: 0, tag: tag};
        sx   = (xa >> (wd - 1)) & 1;
        sy   = (ya >> (wd - 1)) & 1;
        case (o)
            3'd0, 3'd1: begin
                full  = xa + ya + ci;
                e.res = 16'(full & mask);
                e.cf  = ((full >> wd) & 1) != 0;
                e.af  = ((xa & 15) + (ya & 15) + ci) > 15;
                sr    = (full >> (wd - 1)) & 1;
                e.of  = (sx == sy) && (sr != sx);
            end
            3'd2, 3'd3, 3'd7: begin
                full  = xa - ya - ci;
                e.res = 16'(full & mask);
                e.cf  = xa < (ya + ci);
                e.af  = (xa & 15) < ((ya & 15) + ci);
                sr    = (int'(e.res) >> (wd - 1)) & 1;
                e.of  = (sx != sy) && (sr != sx);
            end
            3'd4: e.res = 16'(xa & ya);
            3'd5: e.res = 16'(xa | ya);
            default: e.res = 16'(xa ^ ya);
        endcase
        e.sf   = ((int'(e.res) >> (wd - 1)) & 1) != 0;
        e.zf   = (e.res == 16'h0000);
        e.pf   = ~(^e.res[7:0]);
        e.nowb = (o == 3'd7);
        return e;
    endfunction

    task automatic drive(input logic [15:0] x, input logic [15:0] y,
                         input logic [2:0] o, input bit w, input bit c,
                         input string tag);
        @(posedge clk);
        a = x; b = y; op = o; wide = w; cin = c;
        sb_q.push_back(model(x, y, o, w, c, tag));
    endtask

    task automatic chk(input bit ok, input string req, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s): actual %h expected %h", req, tag, act, exp);
        end
    endtask

    // Monitor: compare at the falling edge, half a cycle after inputs change
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(res  === e.res,  "R1/R2/R9/R10 result", e.tag, res, e.res);
            chk(cf   === e.cf,   "R3 carry",            e.tag, 16'(cf), 16'(e.cf));
            chk(of   === e.of,   "R4 overflow",         e.tag, 16'(of), 16'(e.of));
            chk(sf   === e.sf,   "R5 sign",             e.tag, 16'(sf), 16'(e.sf));
            chk(zf   === e.zf,   "R6 zero",             e.tag, 16'(zf), 16'(e.zf));
            chk(af   === e.af,   "R7 nibble",           e.tag, 16'(af), 16'(e.af));
            chk(pf   === e.pf,   "R8 parity",           e.tag, 16'(pf), 16'(e.pf));
            chk(nowb === e.nowb, "R11 nowb",            e.tag, 16'(nowb), 16'(e.nowb));
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        lf = 32'h1ACE_B00C;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state inputs: add of zeros -> zero, even parity
        drive(16'h0000, 16'h0000, 3'd0, 1'b1, 1'b0, "R6 idle zero");
        drive(16'h00FF, 16'h0001, 3'd0, 1'b1, 1'b0, "R7 word nibble carry");
        drive(16'h00FF, 16'h0001, 3'd0, 1'b0, 1'b0, "R3 byte carry wrap");
        drive(16'h007F, 16'h0001, 3'd0, 1'b0, 1'b0, "R4 byte overflow");
        drive(16'h7FFF, 16'h0001, 3'd0, 1'b1, 1'b0, "R4 word overflow");
        drive(16'h0000, 16'h0001, 3'd2, 1'b1, 1'b0, "R3 word borrow");
        drive(16'h0080, 16'h0001, 3'd2, 1'b0, 1'b0, "R4 byte sub overflow");
        drive(16'h000F, 16'h0000, 3'd1, 1'b0, 1'b1, "R10 adc carry in");
        drive(16'h0005, 16'h0003, 3'd3, 1'b1, 1'b1, "R10 sbb borrow in");
        drive(16'h0001, 16'h0001, 3'd0, 1'b1, 1'b1, "R10 add ignores carry");
        drive(16'h0005, 16'h0003, 3'd2, 1'b1, 1'b1, "R10 sub ignores carry");
        drive(16'h1234, 16'h1234, 3'd7, 1'b1, 1'b0, "R11 cmp equal");
        drive(16'h0010, 16'h0001, 3'd7, 1'b0, 1'b0, "R11 cmp nibble borrow");
        drive(16'hF0F0, 16'h0FF0, 3'd4, 1'b1, 1'b1, "R9 and");
        drive(16'hAB55, 16'h12AA, 3'd6, 1'b0, 1'b0, "R2 byte xor upper ignored");
        drive(16'h8001, 16'h4002, 3'd5, 1'b1, 1'b0, "R9 or");
        drive(16'hFF00, 16'h1100, 3'd0, 1'b0, 1'b0, "R2 byte add upper ignored");
        drive(16'h8000, 16'h8000, 3'd0, 1'b1, 1'b0, "R3 word carry and overflow");
        // pseudo-random sweep over all codes and widths
        for (int i = 0; i < 400; i++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            drive(lf[15:0], lf[31:16], lf[2:0] ^ lf[18:16], lf[7], lf[11],
                  "R1 sweep");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule